// File: doc/BRIEF.md
# Two-Key Register Write Gate

This block guards a 16-byte memory-mapped register window in front of a watchdog countdown. Software cannot change the two countdown preload values or issue a keep-alive until it has written two key values, in order, to the control offset. A correct key pair opens the gate for exactly one protected write. That write is performed and the gate closes again. Key writes are recognised at any write width. Which protected action a write performs depends on its offset and its width.

The block decodes each write into one of four actions: load the first preload, load the second preload, send a keep-alive pulse, or clear the sticky previous-reset flag. The keep-alive and the flag clear leave the block as single-cycle strobes, registered in the cycle after the write. The countdown logic itself is not part of this block. It only raises `expired_set` to record that the last reset came from the watchdog. A read port returns that flag at one offset and width. Every other read returns zero.

Top module: `regwin_key_gate`

## Requirements
- R1: A write of data 0x80 to offset 0x0C arms the gate from any gate state, at any write width (0 = byte, 1 = 16-bit, 2 = 32-bit).
- R2: A write of data 0x86 to offset 0x0C opens the gate only when it is armed. In the locked state that write is ignored. Any other write while armed leaves the gate armed.
- R3: While the gate is open, the next 16-bit or 32-bit write that is not a key write is performed and then locks the gate. This holds even when that write matches no protected action. A 0x86 write in the open state counts as such a write.
- R4: While the gate is open, a 32-bit write to offset 0x00 loads the first preload and a 32-bit write to offset 0x04 loads the second. Only data bits 19:0 are kept. When the gate is not open, neither preload changes.
- R5: A granted 16-bit write to offset 0x0C with data bit 8 set gives a keep-alive strobe that is high for exactly the one cycle after the write.
- R6: A granted 16-bit write to offset 0x0C with data bit 9 or data bit 12 set gives a one-cycle flag-clear strobe and clears the previous-reset flag. The same data written at another width has no effect.
- R7: A 16-bit read of offset 0x0C returns 0x1200 while the previous-reset flag is set. Every other read, and that read while the flag is clear, returns zero.
- R8: Byte writes never perform a protected action and never close an open gate.
- R9: After reset both preloads hold 0xFFFFF, the gate is locked, and the flag and both strobes are low. `expired_set` sets the flag and takes priority over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | 4 | Byte offset of the write in the window |
| wr_size | input | 2 | Write width: 0 byte, 1 16-bit, 2 32-bit |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request this cycle |
| rd_addr | input | 4 | Byte offset of the read |
| rd_size | input | 2 | Read width, same encoding as wr_size |
| rd_data | output | 32 | Read data, combinational |
| expired_set | input | 1 | Countdown request to set the previous-reset flag |
| preload_o | output | 40 | Preloads, first in bits 19:0, second in bits 39:20 |
| keepalive_o | output | 1 | One-cycle keep-alive strobe |
| flag_clr_o | output | 1 | One-cycle flag-clear strobe |
| reset_flag_o | output | 1 | Previous-reset flag |

## Verification
The gate state cannot be seen at the ports, so the hardest cases are the ones where the state changes without any visible output. Examples are a byte write that leaves the gate open, a stray write that keeps it armed, and a repeated first key that re-arms an open gate. Each such case is followed by a 32-bit preload write that would show a new value only if the gate were open at that point. Whether the preload moves therefore shows the hidden state. Writes that consume the grant without acting, such as a 16-bit write to a preload offset, are followed in the same way by a preload write that must be refused.

// File: rtl/kg_pkg.sv
package kg_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } wsize_e;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_ARMED  = 2'd1,
        KS_OPEN   = 2'd2
    } kstate_e;

endpackage

// File: rtl/kg_key_seq.sv
module kg_key_seq
    import kg_pkg::*;
#(
    parameter int          ADDR_W  = 4,
    parameter int          DATA_W  = 32,
    parameter logic [31:0] KEY_ONE = 32'h80,
    parameter logic [31:0] KEY_TWO = 32'h86,
    parameter int          KEY_OFS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    output logic              grant_o,
    output kstate_e           state_o
);

    localparam logic [ADDR_W-1:0] KOFS = ADDR_W'(KEY_OFS);

    typedef struct packed {
        kstate_e st;
    } seq_t;

    seq_t q, d;
    logic hit_one, hit_two, narrow;

    always_comb begin
        hit_one = wr_en && (wr_addr == KOFS) && (wr_data == DATA_W'(KEY_ONE));
        hit_two = wr_en && (wr_addr == KOFS) && (wr_data == DATA_W'(KEY_TWO))
                  && (q.st == KS_ARMED);
        narrow  = (wsize_e'(wr_size) == SZ_BYTE);
        grant_o = wr_en && (q.st == KS_OPEN) && !hit_one && !narrow;
        d = q;
        if (hit_one) begin
            d.st = KS_ARMED;
        end else if (hit_two) begin
            d.st = KS_OPEN;
        end else if (grant_o) begin
            d.st = KS_LOCKED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st <= KS_LOCKED;
        end else begin
            q <= d;
        end
    end

    assign state_o = q.st;

    AST_KEY_ONE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == KOFS && wr_data == DATA_W'(KEY_ONE)) |=> (q.st == KS_ARMED)); // R1

    AST_OPEN_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) != KS_ARMED && $past(q.st) != KS_OPEN) |-> (q.st != KS_OPEN)); // R2

    AST_GRANT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == KS_OPEN && wr_en && wsize_e'(wr_size) != SZ_BYTE
         && !(wr_addr == KOFS && wr_data == DATA_W'(KEY_ONE))) |=> (q.st == KS_LOCKED)); // R3

    AST_BYTE_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == KS_OPEN && wr_en && wsize_e'(wr_size) == SZ_BYTE
         && !(wr_addr == KOFS && wr_data == DATA_W'(KEY_ONE))) |=> (q.st == KS_OPEN)); // R8

endmodule

// File: rtl/kg_actions.sv
module kg_actions
    import kg_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int PRELOAD_W   = 20,
    parameter int NUM_PRELOAD = 2,
    parameter int KEY_OFS     = 12,
    parameter int KEEP_BIT    = 8,
    parameter int CLR_BIT_A   = 9,
    parameter int CLR_BIT_B   = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             grant,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [1:0]                       wr_size,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             expired_set,
    output logic [NUM_PRELOAD*PRELOAD_W-1:0] preload_o,
    output logic                             keepalive_o,
    output logic                             flag_clr_o,
    output logic                             flag_o
);

    localparam logic [ADDR_W-1:0] KOFS = ADDR_W'(KEY_OFS);

    typedef struct packed {
        logic [NUM_PRELOAD-1:0][PRELOAD_W-1:0] pre;
        logic                                  keep;
        logic                                  clr;
        logic                                  flag;
    } act_t;

    act_t q, d;
    logic half_ctl;

    always_comb begin
        half_ctl = grant && (wsize_e'(wr_size) == SZ_HALF) && (wr_addr == KOFS);
        d      = q;
        d.keep = half_ctl && wr_data[KEEP_BIT];
        d.clr  = half_ctl && (wr_data[CLR_BIT_A] || wr_data[CLR_BIT_B]);
        for (int i = 0; i < NUM_PRELOAD; i++) begin
            if (grant && (wsize_e'(wr_size) == SZ_WORD) && (wr_addr == ADDR_W'(i * 4))) begin
                d.pre[i] = wr_data[PRELOAD_W-1:0];
            end
        end
        if (expired_set) begin
            d.flag = 1'b1;
        end else if (d.clr) begin
            d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.pre  <= '1;
            q.keep <= 1'b0;
            q.clr  <= 1'b0;
            q.flag <= 1'b0;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < NUM_PRELOAD; g++) begin : g_pre
        assign preload_o[g*PRELOAD_W +: PRELOAD_W] = q.pre[g];
    end

    assign keepalive_o = q.keep;
    assign flag_clr_o  = q.clr;
    assign flag_o      = q.flag;

    AST_PRELOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && wsize_e'(wr_size) == SZ_WORD) |=> $stable(q.pre)); // R4

    AST_KEEP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.keep && !half_ctl) |=> !q.keep); // R5

    AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (q.clr && !$past(expired_set)) |-> !q.flag); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        expired_set |=> q.flag); // R9

endmodule

// File: rtl/regwin_key_gate.sv
module regwin_key_gate
    import kg_pkg::*;
#(
    parameter int          WIN_BYTES   = 16,
    parameter int          DATA_W      = 32,
    parameter int          PRELOAD_W   = 20,
    parameter int          NUM_PRELOAD = 2,
    parameter logic [31:0] KEY_ONE     = 32'h80,
    parameter logic [31:0] KEY_TWO     = 32'h86,
    parameter int          KEEP_BIT    = 8,
    parameter int          CLR_BIT_A   = 9,
    parameter int          CLR_BIT_B   = 12,
    localparam int         ADDR_W      = $clog2(WIN_BYTES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [1:0]                       wr_size,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             rd_en,
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [1:0]                       rd_size,
    output logic [DATA_W-1:0]                rd_data,
    input  logic                             expired_set,
    output logic [NUM_PRELOAD*PRELOAD_W-1:0] preload_o,
    output logic                             keepalive_o,
    output logic                             flag_clr_o,
    output logic                             reset_flag_o
);

    localparam int                KEY_OFS = WIN_BYTES - 4;
    localparam logic [DATA_W-1:0] FLAG_RD = (DATA_W'(1) << CLR_BIT_A) | (DATA_W'(1) << CLR_BIT_B);

    logic    grant;
    kstate_e gate_st;

    kg_key_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .KEY_ONE(KEY_ONE),
        .KEY_TWO(KEY_TWO),
        .KEY_OFS(KEY_OFS)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_size(wr_size),
        .wr_data(wr_data),
        .grant_o(grant),
        .state_o(gate_st)
    );

    kg_actions #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PRELOAD_W  (PRELOAD_W),
        .NUM_PRELOAD(NUM_PRELOAD),
        .KEY_OFS    (KEY_OFS),
        .KEEP_BIT   (KEEP_BIT),
        .CLR_BIT_A  (CLR_BIT_A),
        .CLR_BIT_B  (CLR_BIT_B)
    ) u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant      (grant),
        .wr_addr    (wr_addr),
        .wr_size    (wr_size),
        .wr_data    (wr_data),
        .expired_set(expired_set),
        .preload_o  (preload_o),
        .keepalive_o(keepalive_o),
        .flag_clr_o (flag_clr_o),
        .flag_o     (reset_flag_o)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en && rd_addr == ADDR_W'(KEY_OFS) && wsize_e'(rd_size) == SZ_HALF && reset_flag_o) begin
            rd_data = FLAG_RD;
        end
    end

    AST_KEEP_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        keepalive_o |-> $past(gate_st == KS_OPEN && wr_en && wsize_e'(wr_size) == SZ_HALF)); // R5

    AST_BYTE_NO_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsize_e'(wr_size) == SZ_BYTE) |=> (!keepalive_o && !flag_clr_o)); // R8

endmodule

// File: tb/regwin_key_gate_test.sv
module regwin_key_gate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [1:0]  rd_size = '0;
    logic [31:0] rd_data;
    logic        expired_set = 1'b0;
    logic [39:0] preload_o;
    logic        keepalive_o, flag_clr_o, reset_flag_o;

    int checks = 0;
    int errors = 0;

    localparam logic [1:0] B = 2'd0, H = 2'd1, W = 2'd2;

    always #10 clk = ~clk;

    regwin_key_gate uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_data(rd_data), .expired_set(expired_set), .preload_o(preload_o),
        .keepalive_o(keepalive_o), .flag_clr_o(flag_clr_o), .reset_flag_o(reset_flag_o)
    );

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one write; returns at the negedge after the capturing edge.
    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] dat);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_size = s; wr_data = dat;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic unlock();
        wr(4'hC, H, 32'h80);
        wr(4'hC, H, 32'h86);
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a; rd_size = s;
        #1 v = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 preloads", preload_o, {20'hFFFFF, 20'hFFFFF});
        check("R9 keepalive", {39'd0, keepalive_o}, 40'd0);
        check("R9 flag_clr", {39'd0, flag_clr_o}, 40'd0);
        check("R9 flag", {39'd0, reset_flag_o}, 40'd0);
    endtask

    task automatic t_preloads();
        wr(4'h0, W, 32'h00011111);
        check("R4 locked write refused", preload_o[19:0], 20'hFFFFF);
        unlock();
        wr(4'h0, W, 32'hABC12345);
        check("R4 first preload low 20 bits", preload_o[19:0], 20'h12345);
        wr(4'h0, W, 32'h00054321);
        check("R3 gate closed after grant", preload_o[19:0], 20'h12345);
        unlock();
        wr(4'h4, W, 32'hFFF6789A);
        check("R4 second preload", preload_o[39:20], 20'h6789A);
        check("R4 first untouched", preload_o[19:0], 20'h12345);
    endtask

    task automatic t_keys();
        wr(4'hC, H, 32'h86);
        wr(4'h0, W, 32'h00000001);
        check("R2 second key ignored when locked", preload_o[19:0], 20'h12345);
        wr(4'hC, W, 32'h80);
        wr(4'h8, W, 32'h00000077);
        wr(4'hC, W, 32'h86);
        wr(4'h0, W, 32'h00000002);
        check("R2 stray write keeps armed", preload_o[19:0], 20'h00002);
        unlock();
        wr(4'hC, B, 32'h80);
        wr(4'h0, W, 32'h00000003);
        check("R1 first key re-arms open gate", preload_o[19:0], 20'h00002);
        wr(4'hC, B, 32'h86);
        wr(4'h0, W, 32'h00000004);
        check("R1 byte keys open gate", preload_o[19:0], 20'h00004);
        unlock();
        wr(4'hC, H, 32'h86);
        wr(4'h0, W, 32'h00000005);
        check("R3 second key in open state consumes grant", preload_o[19:0], 20'h00004);
    endtask

    task automatic t_bytes();
        unlock();
        wr(4'h0, B, 32'h00000055);
        check("R8 byte write no preload", preload_o[19:0], 20'h00004);
        wr(4'hC, B, 32'h00000001);
        check("R8 byte write no strobe", {38'd0, keepalive_o, flag_clr_o}, 40'd0);
        wr(4'h0, W, 32'h00000006);
        check("R8 gate still open after bytes", preload_o[19:0], 20'h00006);
    endtask

    task automatic t_width();
        unlock();
        wr(4'h0, H, 32'h00000007);
        check("R3 half write to preload no effect", preload_o[19:0], 20'h00006);
        wr(4'h0, W, 32'h00000008);
        check("R3 half write consumed grant", preload_o[19:0], 20'h00006);
        unlock();
        wr(4'hC, W, 32'h00000100);
        check("R5 word write no keepalive", {39'd0, keepalive_o}, 40'd0);
    endtask

    task automatic t_keepalive();
        unlock();
        wr(4'hC, H, 32'h00000100);
        check("R5 keepalive strobe", {39'd0, keepalive_o}, 40'd1);
        @(negedge clk);
        check("R5 keepalive one cycle", {39'd0, keepalive_o}, 40'd0);
        wr(4'hC, H, 32'h00000100);
        check("R5 no keepalive when locked", {39'd0, keepalive_o}, 40'd0);
    endtask

    task automatic t_flag();
        logic [31:0] v;
        rd(4'hC, H, v);
        check("R7 clear flag reads zero", {8'd0, v}, 40'd0);
        @(negedge clk); expired_set = 1'b1;
        @(negedge clk); expired_set = 1'b0;
        check("R9 flag set", {39'd0, reset_flag_o}, 40'd1);
        rd(4'hC, H, v);
        check("R7 flag read", {8'd0, v}, 40'h1200);
        rd(4'hC, W, v);
        check("R7 word read zero", {8'd0, v}, 40'd0);
        rd(4'h8, H, v);
        check("R7 other offset zero", {8'd0, v}, 40'd0);
        unlock();
        wr(4'hC, W, 32'h00001000);
        check("R6 word clear ignored", {39'd0, reset_flag_o}, 40'd1);
        unlock();
        wr(4'hC, H, 32'h00001000);
        check("R6 clear strobe bit12", {39'd0, flag_clr_o}, 40'd1);
        check("R6 flag cleared bit12", {39'd0, reset_flag_o}, 40'd0);
        @(negedge clk);
        check("R6 clear strobe one cycle", {39'd0, flag_clr_o}, 40'd0);
        @(negedge clk); expired_set = 1'b1;
        @(negedge clk); expired_set = 1'b0;
        unlock();
        wr(4'hC, H, 32'h00000200);
        check("R6 flag cleared bit9", {39'd0, reset_flag_o}, 40'd0);
        @(negedge clk); expired_set = 1'b1;
        unlock();
        wr(4'hC, H, 32'h00000200);
        check("R9 set wins over clear", {39'd0, reset_flag_o}, 40'd1);
        expired_set = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_preloads();
        t_keys();
        t_bytes();
        t_width();
        t_keepalive();
        t_flag();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule